// File: doc/BRIEF.md
# System Configuration Register Block

This block holds the chip-level configuration settings of a small microcontroller behind a simple word-addressed register bus. The bus has an address, a write strobe, write data and combinational read data. Software uses it to choose the memory that answers at address zero and to set per-peripheral DMA channel remap bits and I2C high-drive pad enables. It also selects the source of the infrared envelope and maps each of sixteen external-interrupt lines to one of six GPIO ports.

A set of lock-enable bits decides which fault sources reach the timer's break input. Those sources are a supply-voltage monitor event, an SRAM parity error and a processor lockup. Once set, a lock-enable bit stays set until a system reset clears it. The block has two synchronous, active-low resets. The system reset returns everything to its initial state and loads the memory mode from the boot-option pins. The bus reset clears only the ordinary settings, and leaves both the memory mode and the lock-enable bits as they were.

Top module: `sysctl_regs`

## Requirements
- R1: The memory mode is `mem_map_o`, in register 0 bits [1:0]. A system reset loads it from `boot_mode_i`, and a write to register 0 replaces it.
- R2: A bus reset clears the DMA remap, high-drive, infrared and interrupt-line select fields and leaves the memory mode unchanged.
- R3: Register 0 bits [6:2] drive `dma_remap_o`, where a 1 moves that peripheral's request to its alternate channel. Register 0 bits [15:8] drive `i2c_drive_o`.
- R4: Register 0 bits [17:16] hold the infrared envelope source, with legal codes 0, 1 and 2. A write with one of these codes replaces the field. A write with code 3 leaves the field unchanged, so `ir_env_o` never shows 3.
- R5: Interrupt line n is selected by the 4-bit field at register 2+(n>>2), bits 4*(n&3)+3 down to 4*(n&3). Port codes 0 to 5 stand for ports A to F. With a valid code c, `irq_line_o[n]` equals `port_pins_i[16*c+n]`. The selectors reset to 0, which is port A.
- R6: A selector holding a reserved code from 6 to 15 drives its interrupt line low.
- R7: Port F has only pins 0 to 10, so any line above 10 that selects port F (code 5) is driven low.
- R8: Register 1 bits [2:0] are the lock-enable bits: bit 0 for the voltage monitor, bit 1 for SRAM parity, bit 2 for lockup. A write can only set them, and writing 0 has no effect. A bus reset does not change them, and only a system reset clears them.
- R9: `brk_o` is registered. It is high in the cycle after one in which some `fault_i[k]` and its lock-enable bit were both 1. Either reset drives it low.
- R10: Reads return every implemented bit, and unimplemented bits read as 0. Addresses 6 and 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | System reset, active low, synchronous; resets everything |
| bus_rst_n | input | 1 | Bus reset, active low, synchronous; spares memory mode and lock bits |
| boot_mode_i | input | 2 | Boot option loaded into the memory mode on system reset |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| port_pins_i | input | 96 | Pin levels of ports A to F, 16 bits each, port A in the low bits |
| fault_i | input | 3 | Fault sources: voltage monitor, SRAM parity, lockup |
| brk_o | output | 1 | Registered timer break request |
| mem_map_o | output | 2 | Memory selected at address zero |
| dma_remap_o | output | 5 | DMA channel remap bits |
| i2c_drive_o | output | 8 | I2C high-drive enables |
| ir_env_o | output | 2 | Infrared envelope source |
| irq_line_o | output | 16 | Routed external-interrupt lines |

## Verification
The in-line assertions check five properties on every cycle. The lock-enable bits never clear without a system reset. A bus reset leaves both the memory mode and the lock bits untouched. A raised break always traces back to an enabled fault one cycle earlier. The infrared field never holds the reserved code, and lines 11 to 15 stay low whenever they select port F. The remaining behaviour is shown only by the bench's scenarios, where a behavioural model is compared against the outputs and the read data on every clock. That covers the exact bit layout of each register, the selector packing, reserved port codes, the ignored code-3 write, the set-only write semantics, the unmapped addresses and the reload of the boot option on system reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    // Geometry of the routed ports and lines
    parameter int NUM_PORTS      = 6;
    parameter int PINS_PER_PORT  = 16;
    parameter int NUM_LINES      = 16;
    parameter int SEL_BITS       = 4;
    parameter int PORTF_LAST_PIN = 10;
    // Field widths
    parameter int MEM_BITS  = 2;
    parameter int DMA_BITS  = 5;
    parameter int DRV_BITS  = 8;
    parameter int IR_BITS   = 2;
    parameter int LOCK_BITS = 3;
    parameter int DATA_W    = 32;

    localparam int LINES_PER_REG = 4;
    localparam int SEL_REGS      = NUM_LINES / LINES_PER_REG;
    localparam int SEL_REG_W     = LINES_PER_REG * SEL_BITS;
    localparam int LAST_PORT     = NUM_PORTS - 1;
    localparam int PIN_BUS_W     = NUM_PORTS * PINS_PER_PORT;

    // Register 0 field positions
    localparam int MEM_LSB = 0;
    localparam int DMA_LSB = MEM_LSB + MEM_BITS;
    localparam int DRV_LSB = 8;
    localparam int IR_LSB  = DRV_LSB + DRV_BITS;
    localparam logic [IR_BITS-1:0] IR_RESERVED = '1;

    // Word addresses
    localparam int A_CFG1 = 0;
    localparam int A_CFG2 = 1;
    localparam int A_SEL0 = 2;

    typedef struct packed {
        logic [MEM_BITS-1:0]            mem;
        logic [DMA_BITS-1:0]            dma;
        logic [DRV_BITS-1:0]            drv;
        logic [IR_BITS-1:0]             ir;
        logic [NUM_LINES*SEL_BITS-1:0]  sel;
        logic [LOCK_BITS-1:0]           lock;
    } cfg_t;
endpackage

// File: rtl/sysctl_line_mux.sv
module sysctl_line_mux
    import sysctl_pkg::*;
#(
    parameter int LINE = 0
) (
    input  logic [SEL_BITS-1:0]  sel_i,
    input  logic [PIN_BUS_W-1:0] pins_i,
    output logic                 line_o
);
    // A port is usable for this line unless it is the short last port
    function automatic logic port_has_pin(input int p);
        return (p != LAST_PORT) || (LINE <= PORTF_LAST_PIN);
    endfunction

    always_comb begin
        line_o = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel_i == SEL_BITS'(p) && port_has_pin(p)) begin
                line_o = pins_i[p*PINS_PER_PORT + LINE];
            end
        end
    end
endmodule

// File: rtl/sysctl_break.sv
module sysctl_break
    import sysctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LOCK_BITS-1:0] fault_i,
    input  logic [LOCK_BITS-1:0] en_i,
    output logic                 brk_o
);
    logic brk_d, brk_q;

    always_comb begin
        brk_d = |(fault_i & en_i);
        if (!rst_n) brk_d = 1'b0;
    end

    always_ff @(posedge clk) brk_q <= brk_d;

    assign brk_o = brk_q;
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    sys_rst_n,
    input  logic                    bus_rst_n,
    input  logic [MEM_BITS-1:0]     boot_mode_i,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [PIN_BUS_W-1:0]    port_pins_i,
    input  logic [LOCK_BITS-1:0]    fault_i,
    output logic                    brk_o,
    output logic [MEM_BITS-1:0]     mem_map_o,
    output logic [DMA_BITS-1:0]     dma_remap_o,
    output logic [DRV_BITS-1:0]     i2c_drive_o,
    output logic [IR_BITS-1:0]      ir_env_o,
    output logic [NUM_LINES-1:0]    irq_line_o
);
    cfg_t st_d, st_q;
    logic any_rst_n;

    assign any_rst_n = sys_rst_n & bus_rst_n;

    // Next-state logic, reset priority included
    always_comb begin
        st_d = st_q;
        if (!sys_rst_n) begin
            st_d     = '0;
            st_d.mem = boot_mode_i;
        end else if (!bus_rst_n) begin
            st_d.dma = '0;
            st_d.drv = '0;
            st_d.ir  = '0;
            st_d.sel = '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(A_CFG1)) begin
                st_d.mem = bus_wdata[MEM_LSB +: MEM_BITS];
                st_d.dma = bus_wdata[DMA_LSB +: DMA_BITS];
                st_d.drv = bus_wdata[DRV_LSB +: DRV_BITS];
                if (bus_wdata[IR_LSB +: IR_BITS] != IR_RESERVED) begin
                    st_d.ir = bus_wdata[IR_LSB +: IR_BITS];
                end
            end else if (bus_addr == ADDR_W'(A_CFG2)) begin
                st_d.lock = st_q.lock | bus_wdata[LOCK_BITS-1:0];
            end else begin
                for (int r = 0; r < SEL_REGS; r++) begin
                    if (bus_addr == ADDR_W'(A_SEL0 + r)) begin
                        st_d.sel[r*SEL_REG_W +: SEL_REG_W] = bus_wdata[SEL_REG_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CFG1)) begin
            bus_rdata[MEM_LSB +: MEM_BITS] = st_q.mem;
            bus_rdata[DMA_LSB +: DMA_BITS] = st_q.dma;
            bus_rdata[DRV_LSB +: DRV_BITS] = st_q.drv;
            bus_rdata[IR_LSB  +: IR_BITS]  = st_q.ir;
        end else if (bus_addr == ADDR_W'(A_CFG2)) begin
            bus_rdata[LOCK_BITS-1:0] = st_q.lock;
        end else begin
            for (int r = 0; r < SEL_REGS; r++) begin
                if (bus_addr == ADDR_W'(A_SEL0 + r)) begin
                    bus_rdata[SEL_REG_W-1:0] = st_q.sel[r*SEL_REG_W +: SEL_REG_W];
                end
            end
        end
    end

    assign mem_map_o   = st_q.mem;
    assign dma_remap_o = st_q.dma;
    assign i2c_drive_o = st_q.drv;
    assign ir_env_o    = st_q.ir;

    // One multiplexer per interrupt line
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        sysctl_line_mux #(.LINE(n)) u_mux (
            .sel_i  (st_q.sel[n*SEL_BITS +: SEL_BITS]),
            .pins_i (port_pins_i),
            .line_o (irq_line_o[n])
        );
        if (n > PORTF_LAST_PIN) begin : g_short
            // R7
            portf_high_line_low_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
                (st_q.sel[n*SEL_BITS +: SEL_BITS] == SEL_BITS'(LAST_PORT)) |-> !irq_line_o[n]);
        end
    end

    sysctl_break u_break (
        .clk     (clk),
        .rst_n   (any_rst_n),
        .fault_i (fault_i),
        .en_i    (st_q.lock),
        .brk_o   (brk_o)
    );

    // R2
    mem_kept_on_bus_rst_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !bus_rst_n |=> $stable(mem_map_o));

    // R8
    lock_kept_on_bus_rst_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !bus_rst_n |=> $stable(st_q.lock));

    // R8
    lock_never_clears_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $past(sys_rst_n) |-> ((st_q.lock & $past(st_q.lock)) == $past(st_q.lock)));

    // R9
    brk_has_cause_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
        brk_o |-> $past(|(fault_i & st_q.lock)));

    // R4
    ir_code_legal_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ir_env_o != IR_RESERVED);
endmodule

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;
    logic        clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic [1:0]  boot_mode_i = 2'd1;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [95:0] port_pins_i = '0;
    logic [2:0]  fault_i = '0;
    logic        brk_o;
    logic [1:0]  mem_map_o;
    logic [4:0]  dma_remap_o;
    logic [7:0]  i2c_drive_o;
    logic [1:0]  ir_env_o;
    logic [15:0] irq_line_o;

    int tests = 0;
    int fails = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_regs u0 (
        .clk(clk), .sys_rst_n(sys_rst_n), .bus_rst_n(bus_rst_n),
        .boot_mode_i(boot_mode_i), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_pins_i(port_pins_i),
        .fault_i(fault_i), .brk_o(brk_o), .mem_map_o(mem_map_o),
        .dma_remap_o(dma_remap_o), .i2c_drive_o(i2c_drive_o),
        .ir_env_o(ir_env_o), .irq_line_o(irq_line_o)
    );

    // Behavioural reference model
    int m_mem, m_dma, m_drv, m_ir, m_lock, m_brk;
    int m_sel [16];

    initial begin
        m_mem = 0; m_dma = 0; m_drv = 0; m_ir = 0; m_lock = 0; m_brk = 0;
        foreach (m_sel[i]) m_sel[i] = 0;
    end

    always @(posedge clk) begin
        if (!sys_rst_n) begin
            m_mem = boot_mode_i; m_dma = 0; m_drv = 0; m_ir = 0;
            m_lock = 0; m_brk = 0;
            foreach (m_sel[i]) m_sel[i] = 0;
        end else if (!bus_rst_n) begin
            m_dma = 0; m_drv = 0; m_ir = 0; m_brk = 0;
            foreach (m_sel[i]) m_sel[i] = 0;
        end else begin
            m_brk = ((fault_i & m_lock[2:0]) != 0) ? 1 : 0;
            if (bus_we) begin
                if (bus_addr == 0) begin
                    m_mem = bus_wdata[1:0];
                    m_dma = bus_wdata[6:2];
                    m_drv = bus_wdata[15:8];
                    if (bus_wdata[17:16] != 2'd3) m_ir = bus_wdata[17:16];
                end else if (bus_addr == 1) begin
                    m_lock = m_lock | bus_wdata[2:0];
                end else if (bus_addr >= 2 && bus_addr <= 5) begin
                    for (int k = 0; k < 4; k++)
                        m_sel[(bus_addr - 2) * 4 + k] = (bus_wdata >> (4 * k)) & 15;
                end
            end
        end
    end

    function automatic logic exp_line(int n);
        int c = m_sel[n];
        if (c > 5) return 1'b0;
        if (c == 5 && n > 10) return 1'b0;
        return port_pins_i[16 * c + n];
    endfunction

    function automatic logic [31:0] exp_rdata();
        logic [31:0] v = '0;
        case (bus_addr)
            3'd0: v = 32'(m_mem) | (32'(m_dma) << 2) | (32'(m_drv) << 8) | (32'(m_ir) << 16);
            3'd1: v = 32'(m_lock);
            3'd2, 3'd3, 3'd4, 3'd5:
                for (int k = 0; k < 4; k++)
                    v = v | (32'(m_sel[(int'(bus_addr) - 2) * 4 + k]) << (4 * k));
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk(mem_map_o == 2'(m_mem), "R1 mem_map_o", mem_map_o, m_mem);
            chk(dma_remap_o == 5'(m_dma), "R3 dma_remap_o", dma_remap_o, m_dma);
            chk(i2c_drive_o == 8'(m_drv), "R3 i2c_drive_o", i2c_drive_o, m_drv);
            chk(ir_env_o == 2'(m_ir), "R4 ir_env_o", ir_env_o, m_ir);
            chk(brk_o == 1'(m_brk), "R9 brk_o", brk_o, m_brk);
            chk(bus_rdata == exp_rdata(), "R10 bus_rdata", bus_rdata, exp_rdata());
            for (int n = 0; n < 16; n++) begin
                if (irq_line_o[n] != exp_line(n)) begin
                    if (m_sel[n] > 5)
                        chk(1'b0, "R6 irq_line_o", irq_line_o[n], exp_line(n));
                    else if (m_sel[n] == 5 && n > 10)
                        chk(1'b0, "R7 irq_line_o", irq_line_o[n], exp_line(n));
                    else
                        chk(1'b0, "R5 irq_line_o", irq_line_o[n], exp_line(n));
                end
            end
            tests++;
        end
    end

    task automatic cyc(input logic [2:0] a, input logic we, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = we; bus_wdata = d;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        cmp_en = 1'b1;
        #1; sys_rst_n = 1'b1; bus_rst_n = 1'b1;
        cyc(3'd0, 1'b0, 0);
        @(negedge clk);
        chk(mem_map_o == 2'd1, "R1 boot option loaded", mem_map_o, 1);
        chk(irq_line_o == 16'h0 && brk_o == 1'b0, "R5 reset state", irq_line_o, 0);

        // R3 R4 register 0 fields
        cyc(3'd0, 1'b1, 32'h3 | (32'h15 << 2) | (32'hA5 << 8) | (32'h2 << 16));
        cyc(3'd0, 1'b1, 32'h3 | (32'h15 << 2) | (32'hA5 << 8) | (32'h3 << 16));
        cyc(3'd0, 1'b0, 0);
        @(negedge clk);
        chk(dma_remap_o == 5'h15 && i2c_drive_o == 8'hA5, "R3 remap and drive", {dma_remap_o, i2c_drive_o}, {5'h15, 8'hA5});
        chk(ir_env_o == 2'd2, "R4 code 3 ignored", ir_env_o, 2);

        // R5 R6 R7 line selectors
        port_pins_i = '1;
        cyc(3'd2, 1'b1, 32'h5432);
        cyc(3'd3, 1'b1, 32'h1010);
        cyc(3'd4, 1'b1, 32'h5F65);
        cyc(3'd5, 1'b1, 32'hFFFF5555);
        cyc(3'd5, 1'b0, 0);
        @(negedge clk);
        chk(irq_line_o == 16'h01FF, "R5 R6 R7 line routing", irq_line_o, 16'h01FF);
        chk(bus_rdata == 32'h5555, "R10 upper selector bits ignored", bus_rdata, 32'h5555);
        port_pins_i = 96'h0;
        port_pins_i[16 * 2 + 0] = 1'b1;
        cyc(3'd5, 1'b0, 0);
        @(negedge clk);
        chk(irq_line_o == 16'h0001, "R5 single pin from port C", irq_line_o, 1);

        // R8 R9 lock bits and break
        cyc(3'd1, 1'b1, 32'h2);
        fault_i = 3'b101;
        cyc(3'd1, 1'b0, 0);
        @(negedge clk);
        chk(brk_o == 1'b0, "R9 unlocked faults ignored", brk_o, 0);
        fault_i = 3'b010;
        cyc(3'd1, 1'b1, 32'h0);
        fault_i = 3'b000;
        @(negedge clk);
        chk(brk_o == 1'b1 && bus_rdata == 32'h2, "R8 R9 break raised, lock kept", {brk_o, bus_rdata}, {1'b1, 32'h2});
        cyc(3'd1, 1'b0, 0);
        @(negedge clk);
        chk(brk_o == 1'b0, "R9 break follows fault", brk_o, 0);

        // R2 R8 bus reset
        bus_rst_n = 1'b0;
        cyc(3'd0, 1'b0, 0);
        cyc(3'd0, 1'b0, 0);
        bus_rst_n = 1'b1;
        @(negedge clk);
        chk(bus_rdata == 32'h3, "R2 only memory mode kept", bus_rdata, 3);
        cyc(3'd1, 1'b0, 0);
        @(negedge clk);
        chk(bus_rdata == 32'h2, "R8 lock survives bus reset", bus_rdata, 2);

        // R10 unmapped address
        cyc(3'd6, 1'b1, 32'hFFFFFFFF);
        cyc(3'd7, 1'b1, 32'hFFFFFFFF);
        cyc(3'd6, 1'b0, 0);
        @(negedge clk);
        chk(bus_rdata == 32'h0 && i2c_drive_o == 8'h0, "R10 unmapped write ignored", bus_rdata, 0);

        // R1 R8 system reset reloads boot option
        boot_mode_i = 2'd0;
        sys_rst_n = 1'b0;
        cyc(3'd1, 1'b0, 0);
        sys_rst_n = 1'b1;
        @(negedge clk);
        chk(bus_rdata == 32'h0 && mem_map_o == 2'd0, "R1 R8 system reset", {mem_map_o, bus_rdata}, 0);

        // Mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            port_pins_i = {$urandom, $urandom, $urandom};
            fault_i = 3'($urandom);
            boot_mode_i = 2'($urandom);
            bus_rst_n = ($urandom % 40) != 0;
            sys_rst_n = ($urandom % 150) != 0;
            cyc(3'($urandom), 1'($urandom), $urandom);
        end
        cyc(3'd0, 1'b0, 0);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule